// File: doc/BRIEF.md
# Branch and Trap PC Redirect Unit

This block steers the fetch address of a five-stage in-order pipeline. Fetch assumes every conditional branch falls through, so the program counter normally advances by one 4-byte word each cycle. Branches are resolved in the decode stage. The unit compares the two register operands of a branch-if-equal or branch-if-not-equal instruction there and forms the branch target. When the branch is taken, fetch moves to the target and the one wrongly fetched instruction waiting in the fetch/decode register is discarded.

The unit also turns faults into a redirect to a fixed trap handler address. A faulting instruction is either an arithmetic overflow reported by the execute stage or an undefined opcode reported by decode. On a fault, the unit saves that instruction's own address and a code for the kind of fault. It also raises kill signals for the pipeline registers that hold the faulting instruction and any younger ones. Instructions older than the faulting one are left to finish. The surrounding pipeline owns the memories, the register file and the ALU. It feeds this unit the decode-stage branch fields and the execute-stage overflow flag, and it obeys the flush outputs.

Top module: `pc_redirect_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `fetch_pc` equals `RESET_PC` (default 0), and `epc` and `cause` are 0.
- R2: In a cycle with no taken branch and no fault, `fetch_pc` advances by 4 at the next clock edge and all three flush outputs are 0.
- R3: A valid branch-if-equal (`id_op_beq`=1) is taken when `id_src_a` equals `id_src_b`. A taken branch sets `branch_taken`, and the next `fetch_pc` becomes `id_pc + 4 + (sign-extended id_offset * 4)`.
- R4: A valid branch-if-not-equal (`id_op_bne`=1) is taken when the operands differ. A branch that is not taken leaves `branch_taken` at 0 and lets `fetch_pc` advance by 4.
- R5: A taken branch with no fault raises `flush_ifid` only. `flush_idex` and `flush_exmem` stay 0.
- R6: When `ex_overflow` is 1, all three flush outputs are 1 in that cycle and the next `fetch_pc` is `TRAP_PC`.
- R7: After a cycle with `ex_overflow`=1, `epc` holds that cycle's `ex_pc` and `cause` holds 12.
- R8: A valid undefined opcode in decode (`id_valid`=1, `id_undef`=1) with no overflow raises `flush_ifid` and `flush_idex` but not `flush_exmem`. The next `fetch_pc` is `TRAP_PC`, and after that edge `epc` holds `id_pc` and `cause` holds 10.
- R9: A fault takes priority over a taken branch in the same cycle, and an overflow takes priority over an undefined opcode. The older execute-stage instruction is the one whose address and code are saved.
- R10: In a cycle with no fault, `epc` and `cause` keep their values.
- R11: When `id_valid` is 0, the branch and undefined-opcode inputs have no effect. `branch_taken` is 0, there is no flush, and `fetch_pc` advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_op_beq | input | 1 | Decode instruction is branch-if-equal |
| id_op_bne | input | 1 | Decode instruction is branch-if-not-equal |
| id_undef | input | 1 | Decode instruction has an undefined opcode |
| id_pc | input | XLEN | Address of the decode-stage instruction |
| id_offset | input | OFF_W | Branch word offset, signed |
| id_src_a | input | XLEN | First register operand |
| id_src_b | input | XLEN | Second register operand |
| ex_overflow | input | 1 | Execute-stage instruction overflowed |
| ex_pc | input | XLEN | Address of the execute-stage instruction |
| fetch_pc | output | XLEN | Current fetch address |
| branch_taken | output | 1 | Decode-stage branch resolves taken |
| flush_ifid | output | 1 | Kill fetch/decode register contents |
| flush_idex | output | 1 | Kill decode/execute register contents |
| flush_exmem | output | 1 | Kill execute/memory register contents |
| epc | output | XLEN | Address of the last faulting instruction |
| cause | output | 5 | Code of the last fault (12 overflow, 10 undefined) |

## Verification
The branch path is swept over a large set of offsets, including 0, the largest positive value, the most negative value and -1, for both branch kinds. Each offset is tried with equal and unequal operands. This separates a wrong compare sense from a wrong sign extension or a missing shift of the offset. Faults are driven alone, on top of a taken branch, and with both fault kinds together. These cases show whether the priority order and the choice of saved address and code are right, and whether the flush pattern of each fault kind is right. Cycles with invalid decode contents and idle cycles between faults show whether branch and fault inputs are ignored when they should be, and whether the saved registers hold.

// File: rtl/redirect_pkg.sv
// Shared types and codes for the PC redirect unit.
// Assumes a 5-bit fault code field; codes are fixed by the pipeline's trap handler.
package redirect_pkg;
    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CODE_OVERFLOW = 5'd12;
    localparam logic [CAUSE_W-1:0] CODE_UNDEF    = 5'd10;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_TRAP   = 2'd2
    } npc_sel_e;
endpackage

// File: rtl/branch_resolver.sv
// Decode-stage branch resolution: operand equality compare and target adder.
// Assumes a word-aligned address space, so the offset counts 4-byte words.
module branch_resolver #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic            valid,
    input  logic            op_eq,
    input  logic            op_ne,
    input  logic [XLEN-1:0] pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            taken,
    output logic [XLEN-1:0] target
);
    localparam int EXT_W = XLEN - OFF_W - 2;

    logic            same;
    logic [XLEN-1:0] byte_off;

    // Compare operands and decide direction.
    always_comb begin
        same  = (src_a == src_b);
        taken = valid && ((op_eq && same) || (op_ne && !same));
    end

    // Sign-extend the word offset, scale to bytes, add to the next sequential address.
    always_comb begin
        byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
        target   = pc + XLEN'(4) + byte_off;
    end
endmodule

// File: rtl/trap_arbiter.sv
// Picks the fault to service this cycle and which pipeline registers to kill.
// Assumes ex_overflow is already qualified by a valid execute-stage instruction.
module trap_arbiter
    import redirect_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               ex_overflow,
    input  logic [XLEN-1:0]    ex_pc,
    input  logic               id_valid,
    input  logic               id_undef,
    input  logic [XLEN-1:0]    id_pc,
    output logic               trap,
    output logic [XLEN-1:0]    trap_pc,
    output logic [CAUSE_W-1:0] trap_code,
    output logic               kill_idex,
    output logic               kill_exmem
);
    logic undef_hit;

    // Older execute-stage fault wins over a decode-stage fault.
    always_comb begin
        undef_hit  = id_valid && id_undef;
        trap       = ex_overflow || undef_hit;
        kill_exmem = ex_overflow;
        kill_idex  = trap;
        if (ex_overflow) begin
            trap_pc   = ex_pc;
            trap_code = CODE_OVERFLOW;
        end else begin
            trap_pc   = id_pc;
            trap_code = CODE_UNDEF;
        end
    end
endmodule

// File: rtl/epc_cause_regs.sv
// Holds the faulting instruction's address and fault code until the next fault.
// Assumes software reads them through a path outside this block.
module epc_cause_regs
    import redirect_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [CAUSE_W-1:0] trap_code,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    // Capture on a fault, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
        end else if (trap) begin
            epc   <= trap_pc;
            cause <= trap_code;
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
// Fetch PC register with a three-way next-address select: sequential, branch, trap.
// Assumes no fetch stall; the PC moves every cycle.
module pc_sequencer
    import redirect_pkg::*;
#(
    parameter int             XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter logic [XLEN-1:0] TRAP_PC  = 32'h0000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap,
    input  logic            br_taken,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] pc
);
    npc_sel_e        sel;
    logic [XLEN-1:0] next_pc;

    // Priority select: trap over branch over fall-through.
    always_comb begin
        if (trap)          sel = NPC_TRAP;
        else if (br_taken) sel = NPC_BRANCH;
        else               sel = NPC_SEQ;
        case (sel)
            NPC_TRAP:   next_pc = TRAP_PC;
            NPC_BRANCH: next_pc = br_target;
            default:    next_pc = pc + XLEN'(4);
        endcase
    end

    // PC register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else        pc <= next_pc;
    end
endmodule

// File: rtl/pc_redirect_unit.sv
// Top of the PC redirect unit: decode-stage branch resolution, fault arbitration,
// fetch PC and saved fault state. Flush outputs are combinational in the same
// cycle as the event. Assumes the pipeline applies flushes at the same clock edge.
module pc_redirect_unit
    import redirect_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              OFF_W    = 16,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter logic [XLEN-1:0] TRAP_PC  = 32'h0000_0180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid,
    input  logic               id_op_beq,
    input  logic               id_op_bne,
    input  logic               id_undef,
    input  logic [XLEN-1:0]    id_pc,
    input  logic [OFF_W-1:0]   id_offset,
    input  logic [XLEN-1:0]    id_src_a,
    input  logic [XLEN-1:0]    id_src_b,
    input  logic               ex_overflow,
    input  logic [XLEN-1:0]    ex_pc,
    output logic [XLEN-1:0]    fetch_pc,
    output logic               branch_taken,
    output logic               flush_ifid,
    output logic               flush_idex,
    output logic               flush_exmem,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    logic               trap;
    logic [XLEN-1:0]    trap_pc;
    logic [CAUSE_W-1:0] trap_code;
    logic               kill_idex;
    logic               kill_exmem;
    logic [XLEN-1:0]    br_target;

    branch_resolver #(.XLEN(XLEN), .OFF_W(OFF_W)) u_br (
        .valid (id_valid),
        .op_eq (id_op_beq),
        .op_ne (id_op_bne),
        .pc    (id_pc),
        .offset(id_offset),
        .src_a (id_src_a),
        .src_b (id_src_b),
        .taken (branch_taken),
        .target(br_target)
    );

    trap_arbiter #(.XLEN(XLEN)) u_arb (
        .ex_overflow(ex_overflow),
        .ex_pc      (ex_pc),
        .id_valid   (id_valid),
        .id_undef   (id_undef),
        .id_pc      (id_pc),
        .trap       (trap),
        .trap_pc    (trap_pc),
        .trap_code  (trap_code),
        .kill_idex  (kill_idex),
        .kill_exmem (kill_exmem)
    );

    pc_sequencer #(.XLEN(XLEN), .RESET_PC(RESET_PC), .TRAP_PC(TRAP_PC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap     (trap),
        .br_taken (branch_taken),
        .br_target(br_target),
        .pc       (fetch_pc)
    );

    epc_cause_regs #(.XLEN(XLEN)) u_epc (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap     (trap),
        .trap_pc  (trap_pc),
        .trap_code(trap_code),
        .epc      (epc),
        .cause    (cause)
    );

    // Combine flush requests from branch and fault paths.
    always_comb begin
        flush_ifid  = trap || branch_taken;
        flush_idex  = kill_idex;
        flush_exmem = kill_exmem;
    end
endmodule

// File: rtl/pc_redirect_chk.sv
// Property checker for pc_redirect_unit, attached by bind.
module pc_redirect_chk #(
    parameter int              XLEN    = 32,
    parameter logic [XLEN-1:0] TRAP_PC = 32'h0000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid,
    input logic            id_undef,
    input logic [XLEN-1:0] id_pc,
    input logic            ex_overflow,
    input logic [XLEN-1:0] ex_pc,
    input logic [XLEN-1:0] fetch_pc,
    input logic            branch_taken,
    input logic            flush_ifid,
    input logic            flush_idex,
    input logic            flush_exmem,
    input logic [XLEN-1:0] epc,
    input logic [4:0]      cause
);
    logic fault;
    always_comb fault = ex_overflow || (id_valid && id_undef);

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !branch_taken) |=> (fetch_pc == $past(fetch_pc) + 32'd4)); // R2
    AST_BRANCH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_taken && !fault) |-> (flush_ifid && !flush_idex && !flush_exmem)); // R5
    AST_OVF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ex_overflow |-> (flush_ifid && flush_idex && flush_exmem)); // R6
    AST_OVF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_overflow |=> (fetch_pc == TRAP_PC && cause == 5'd12 && epc == $past(ex_pc))); // R7
    AST_UNDEF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_undef && !ex_overflow) |=> (fetch_pc == TRAP_PC && cause == 5'd10 && epc == $past(id_pc))); // R8
    AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |=> ($stable(epc) && $stable(cause))); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid && !ex_overflow) |-> (!branch_taken && !flush_ifid && !flush_idex)); // R11
endmodule

bind pc_redirect_unit pc_redirect_chk #(.XLEN(XLEN), .TRAP_PC(TRAP_PC)) u_chk (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_overflow(ex_overflow), .ex_pc(ex_pc), .fetch_pc(fetch_pc),
    .branch_taken(branch_taken), .flush_ifid(flush_ifid), .flush_idex(flush_idex),
    .flush_exmem(flush_exmem), .epc(epc), .cause(cause)
);

// File: tb/tb_pc_redirect_unit.sv
module tb_pc_redirect_unit;
    localparam logic [31:0] TRAP = 32'h0000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 0, id_op_beq = 0, id_op_bne = 0, id_undef = 0;
    logic [31:0] id_pc = 0, id_src_a = 0, id_src_b = 0, ex_pc = 0;
    logic [15:0] id_offset = 0;
    logic        ex_overflow = 0;
    logic [31:0] fetch_pc, epc;
    logic        branch_taken, flush_ifid, flush_idex, flush_exmem;
    logic [4:0]  cause;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_pc = 0, exp_epc = 0;
    logic [4:0]  exp_cause = 0;

    pc_redirect_unit dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op_beq(id_op_beq),
        .id_op_bne(id_op_bne), .id_undef(id_undef), .id_pc(id_pc), .id_offset(id_offset),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .ex_overflow(ex_overflow), .ex_pc(ex_pc),
        .fetch_pc(fetch_pc), .branch_taken(branch_taken), .flush_ifid(flush_ifid),
        .flush_idex(flush_idex), .flush_exmem(flush_exmem), .epc(epc), .cause(cause)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check flushes before the rising edge,
    // then check registered state just after it.
    task automatic step(input logic v, input logic beq, input logic bne, input logic und,
                        input logic [31:0] ipc, input logic [15:0] off,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic ovf, input logic [31:0] xpc, input string req);
        logic tk, tr;
        logic [31:0] tgt;
        @(negedge clk);
        id_valid = v; id_op_beq = beq; id_op_bne = bne; id_undef = und;
        id_pc = ipc; id_offset = off; id_src_a = a; id_src_b = b;
        ex_overflow = ovf; ex_pc = xpc;
        tk  = v && ((beq && a == b) || (bne && a != b));
        tgt = ipc + 32'd4 + 32'($signed(off)) * 32'd4;
        tr  = ovf || (v && und);
        #1;
        chk({req, " branch_taken"}, {31'd0, branch_taken}, {31'd0, tk});
        chk({req, " flush_ifid"},   {31'd0, flush_ifid},   {31'd0, tk || tr});
        chk({req, " flush_idex"},   {31'd0, flush_idex},   {31'd0, tr});
        chk({req, " flush_exmem"},  {31'd0, flush_exmem},  {31'd0, ovf});
        if (ovf) begin
            exp_pc = TRAP; exp_epc = xpc; exp_cause = 5'd12;
        end else if (v && und) begin
            exp_pc = TRAP; exp_epc = ipc; exp_cause = 5'd10;
        end else if (tk) begin
            exp_pc = tgt;
        end else begin
            exp_pc = exp_pc + 32'd4;
        end
        @(posedge clk); #1;
        chk({req, " fetch_pc"}, fetch_pc, exp_pc);
        chk({req, " epc"}, epc, exp_epc);
        chk({req, " cause"}, {27'd0, cause}, {27'd0, exp_cause});
    endtask

    bit finished = 0;
    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] offs [0:7];
        offs[0] = 16'h0000; offs[1] = 16'h7FFF; offs[2] = 16'h8000; offs[3] = 16'hFFFF;
        offs[4] = 16'h0001; offs[5] = 16'h1234; offs[6] = 16'hC001; offs[7] = 16'h00FF;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 fetch_pc in reset", fetch_pc, 32'd0);
        chk("R1 epc in reset", epc, 32'd0);
        chk("R1 cause in reset", {27'd0, cause}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        exp_pc = 32'd0;
        @(posedge clk); #1;
        exp_pc = 32'd4;
        chk("R1 fetch_pc after reset", fetch_pc, 32'd4);

        // R2: plain sequential cycles
        for (int i = 0; i < 4; i++)
            step(1, 0, 0, 0, 32'h100 + i*4, 16'h0010, 32'd1, 32'd1, 0, 0, "R2");

        // R3 / R4 / R5: offset sweep, both kinds, equal and unequal operands
        for (int k = 0; k < 40; k++) begin
            logic [15:0] off;
            off = (k < 8) ? offs[k] : 16'(k * 16'd2113 + 16'd37);
            for (int m = 0; m < 4; m++) begin
                logic [31:0] a, b;
                a = 32'h1000_0000 + 32'(k);
                b = (m[0]) ? a : a ^ 32'h0000_0100;
                if (m[1]) step(1, 1, 0, 0, 32'h0004_0000 + 32'(k)*64, off, a, b, 0, 0, "R3 R5 beq");
                else      step(1, 0, 1, 0, 32'h0004_0000 + 32'(k)*64, off, a, b, 0, 0, "R4 R5 bne");
            end
        end

        // R6 / R7: overflow alone, then idle hold (R10)
        step(1, 0, 0, 0, 32'h200, 16'h0, 32'd0, 32'd1, 1, 32'h0000_1F0C, "R6 R7 overflow");
        step(1, 0, 0, 0, 32'h204, 16'h0, 32'd0, 32'd1, 0, 32'h0000_2222, "R10 hold");
        step(0, 0, 0, 0, 32'h208, 16'h0, 32'd0, 32'd1, 0, 32'h0000_3333, "R10 hold idle");

        // R8: undefined opcode in decode
        step(1, 0, 0, 1, 32'h0000_5550, 16'h0, 32'd0, 32'd0, 0, 32'h0000_554C, "R8 undef");
        step(1, 0, 0, 0, 32'h300, 16'h0, 32'd0, 32'd1, 0, 0, "R10 hold after undef");

        // R9: overflow beats taken branch; overflow beats undefined; undefined beats branch
        step(1, 1, 0, 0, 32'h0000_6000, 16'h0020, 32'd7, 32'd7, 1, 32'h0000_5FFC, "R9 ovf over branch");
        step(1, 0, 0, 1, 32'h0000_7000, 16'h0, 32'd0, 32'd0, 1, 32'h0000_6FFC, "R9 ovf over undef");
        step(1, 0, 1, 1, 32'h0000_8000, 16'h0040, 32'd1, 32'd2, 0, 32'h0, "R9 undef over branch");

        // R11: invalid decode contents ignored
        for (int i = 0; i < 4; i++)
            step(0, i[0], ~i[0], i[1], 32'h0000_9000, 16'h0100, 32'd5, 32'(5 + i[0]), 0, 0, "R11 invalid");

        // R2 once more after all redirects
        step(1, 0, 0, 0, 32'h400, 16'h0, 32'd0, 32'd0, 0, 0, "R2 tail");

        finish_run();
    end
endmodule